// File: doc/BRIEF.md
# March C- Memory Self-Test Wrapper

This wrapper sits between a 64-word by 8-bit SRAM and the logic that normally uses it. A mode input picks who drives the memory. With the mode low, the functional address, write data and write enable pass straight to the memory. With the mode high, an internal test engine drives them instead. Read data always returns to the functional side unchanged.

The test engine is one packed counter. Its low six bits are the word address. The next four bits are the March C- operation index, which runs from 0 to 9. The top three bits choose the bit of the word under test.

The operations run in this order: w0, r0, w1, r1, w0, r0, w1, r1, w0, r0. Operation 0 is a single-operation element, and so is operation 9. In each of those two the address advances every clock. The other eight operations form four read-then-write pairs:
- In each pair the read and the write fall on the same address, one after the other.
- The first two pairs walk the addresses upward.
- The last two pairs walk the addresses downward, because the counter's address field is inverted on its way to the memory.

The whole ten-operation sequence is repeated once for each of the eight bit positions. A read word that differs from the expected pattern sets a sticky fail flag. One cycle after the counter's final state, a done pulse marks the end of the run.

Top module: `mbist_march_wrap`

## Requirements
- R1: With `test_mode`=1 and the engine idle, a `start` high at a rising edge begins a run. The access for counter value 0 (a write of address 0) is presented during the following cycle. Exactly DATA_W*10*2^ADDR_W (5120) access cycles follow, one per clock.
- R2: Within one bit pass, operations 0, 1, 2, 3 and 4 and the final operation 9 visit addresses in ascending order, 0 to 63. Operations 5, 6, 7 and 8 visit addresses in descending order, 63 to 0. During operation 0 the address rises by one every clock.
- R3: In each pair (operations 1/2, 3/4, 5/6, 7/8), the read cycle (`mem_we`=0) is followed at once by the write cycle (`mem_we`=1) to the same address.
- R4: Even operations are writes and odd operations are reads. The march value is 1 for operations 2, 3, 6 and 7 and 0 for the others. Bit index b (counter bits [12:10]) goes from 0 to 7, one full pass each. The word written is (1<<b) when the march value is 1 and 0 otherwise.
- R5: With `test_mode`=0, `mem_addr`, `mem_wdata` and `mem_we` follow the functional inputs. `fn_rdata` always equals `mem_rdata`.
- R6: `done` is high for exactly one cycle, the cycle after the last access. From that cycle on, the engine is idle and `mem_we` stays 0 in test mode.
- R7: A read cycle whose `mem_rdata` differs from the expected word sets `fail` in the next cycle. `fail` then stays high until an accepted `start`, which clears it.
- R8: `start` has no effect while `test_mode`=0 or while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | 1 selects test access to the memory, 0 selects functional access |
| start | input | 1 | Begins a test run when idle in test mode |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Sticky read-mismatch flag |
| fn_addr | input | ADDR_W | Functional address |
| fn_wdata | input | DATA_W | Functional write data |
| fn_we | input | 1 | Functional write enable |
| fn_rdata | output | DATA_W | Read data returned to the functional side |
| mem_addr | output | ADDR_W | Address to the SRAM |
| mem_wdata | output | DATA_W | Write data to the SRAM |
| mem_we | output | 1 | Write enable to the SRAM |
| mem_rdata | input | DATA_W | SRAM read data, combinational on `mem_addr` |

## Verification
A wrong counter state shows up at the memory port in the very next cycle. It can appear as an address out of order, a write where a read belongs, or the wrong bit set in the write word. For that reason the bench compares every single test-mode access with a position computed from the cycle count.

A broken comparator or fail register shows up as a `fail` edge one cycle away from the injected mismatch. A wrong terminal-count decode moves the `done` pulse away from cycle 5120.

// File: rtl/mbist_march_wrap.sv
module mbist_march_wrap #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              start,
  output logic              done,
  output logic              fail,
  input  logic [ADDR_W-1:0] fn_addr,
  input  logic [DATA_W-1:0] fn_wdata,
  input  logic              fn_we,
  output logic [DATA_W-1:0] fn_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int OP_W    = 4;
  localparam int CNT_W   = ADDR_W + OP_W + BIT_W;
  localparam logic [OP_W-1:0] OP_LAST = OP_W'(9);

  logic             running;
  logic             done_q;
  logic             fail_q;
  logic [CNT_W-1:0] cnt;

  wire [ADDR_W-1:0] c_addr = cnt[ADDR_W-1:0];
  wire [OP_W-1:0]   c_op   = cnt[ADDR_W +: OP_W];
  wire [BIT_W-1:0]  c_bit  = cnt[ADDR_W+OP_W +: BIT_W];

  wire addr_max  = &c_addr;
  wire op_single = (c_op == '0) || (c_op == OP_LAST);
  wire op_first  = c_op[0] && !op_single;
  wire cout      = running && (c_op == OP_LAST) && addr_max && (&c_bit);

  logic [ADDR_W-1:0] n_addr;
  logic [OP_W-1:0]   n_op;
  logic [BIT_W-1:0]  n_bit;

  always_comb begin
    n_addr = c_addr;
    n_op   = c_op;
    n_bit  = c_bit;
    if (op_first) begin
      n_op = c_op + OP_W'(1);
    end else if (!addr_max) begin
      n_addr = c_addr + ADDR_W'(1);
      if (!op_single) n_op = c_op - OP_W'(1);
    end else begin
      n_addr = '0;
      if (c_op == OP_LAST) begin
        n_op  = '0;
        n_bit = c_bit + BIT_W'(1);
      end else begin
        n_op = c_op + OP_W'(1);
      end
    end
  end

  wire              b_desc  = (c_op >= OP_W'(5)) && (c_op <= OP_W'(8));
  wire              b_write = !c_op[0];
  wire              b_val   = (c_op == OP_W'(2)) || (c_op == OP_W'(3)) ||
                              (c_op == OP_W'(6)) || (c_op == OP_W'(7));
  wire [ADDR_W-1:0] b_addr  = b_desc ? ~c_addr : c_addr;
  wire [DATA_W-1:0] b_word  = b_val ? (DATA_W'(1) << c_bit) : '0;
  wire              b_miss  = running && test_mode && !b_write && (mem_rdata != b_word);

  assign mem_addr  = test_mode ? b_addr : fn_addr;
  assign mem_wdata = test_mode ? b_word : fn_wdata;
  assign mem_we    = test_mode ? (running && b_write) : fn_we;
  assign fn_rdata  = mem_rdata;
  assign done      = done_q;
  assign fail      = fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= cout;
      if (!running) begin
        if (start && test_mode) begin
          running <= 1'b1;
          cnt     <= '0;
          fail_q  <= 1'b0;
        end
      end else begin
        cnt <= {n_bit, n_op, n_addr};
        if (cout) running <= 1'b0;
        if (b_miss) fail_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk #(
  parameter int ADDR_W = 6,
  parameter int OP_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_mode,
  input logic              start,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              running,
  input logic [OP_W-1:0]   c_op,
  input logic [ADDR_W-1:0] c_addr
);
  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && test_mode && c_op == '0 && !(&c_addr)) |=>
      (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  a_r3_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && test_mode && c_op[0] && c_op != OP_W'(9)) |=>
      (mem_we && mem_addr == $past(mem_addr)));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && test_mode) |-> !mem_we);

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && test_mode && !running)) |=> fail);

  a_r8_start_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !test_mode) |=> !running);
endmodule

bind mbist_march_wrap mbist_march_chk #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
  .done(done), .fail(fail), .mem_addr(mem_addr), .mem_we(mem_we),
  .running(running), .c_op(c_op), .c_addr(c_addr)
);

// File: tb/sim_mbist_march_wrap.sv
module sim_mbist_march_wrap;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NW = 1 << AW;
  localparam int PASS = 10 * NW;
  localparam int RUN = DW * PASS;

  logic clk = 0;
  logic rst_n = 0;
  logic test_mode = 0, start = 0, fn_we = 0;
  logic [AW-1:0] fn_addr = '0;
  logic [DW-1:0] fn_wdata = '0;
  logic done, fail, mem_we;
  logic [DW-1:0] fn_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic fault_en = 0;
  logic [DW-1:0] ram [NW];

  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  mbist_march_wrap #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
    .done(done), .fail(fail), .fn_addr(fn_addr), .fn_wdata(fn_wdata),
    .fn_we(fn_we), .fn_rdata(fn_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;
  assign mem_rdata = ram[mem_addr] | ((fault_en && mem_addr == AW'(5)) ? DW'(8) : DW'(0));

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d expected<=60000", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_access(input int i, output int ea, output bit ew, output int ed);
    int b, r, op, k, e, j, step;
    b = i / PASS;
    r = i % PASS;
    if (r < NW) begin op = 0; ea = r; end
    else if (r < PASS - NW) begin
      k = r - NW; e = k / (2*NW); j = k % (2*NW); step = j / 2;
      op = 1 + 2*e + (j % 2);
      ea = (e >= 2) ? (NW - 1 - step) : step;
    end else begin op = 9; ea = r - (PASS - NW); end
    ew = (op % 2) == 0;
    ed = (op == 2 || op == 3 || op == 6 || op == 7) ? (1 << b) : 0;
  endtask

  task automatic run_march(input bit with_fault, input int poke_at);
    int ea, ed, mism;
    bit ew;
    fault_en = with_fault;
    start = 1;
    @(negedge clk);
    start = 0;
    mism = -1;
    for (int i = 0; i < RUN; i++) begin
      expect_access(i, ea, ew, ed);
      chk(mem_addr == AW'(ea), "R2", "address", mem_addr, ea);
      chk(mem_we == ew, "R3", "write enable", mem_we, ew);
      if (ew) chk(mem_wdata == DW'(ed), "R4", "write word", mem_wdata, ed);
      chk(done == 0, "R1", "done during run", done, 0);
      chk(fail == (mism >= 0 && i > mism), "R7", "fail flag", fail, (mism >= 0 && i > mism));
      if (!ew && with_fault && ea == 5 && ((ed & 8) == 0) && mism < 0) mism = i;
      start = (i == poke_at);
      @(negedge clk);
    end
    start = 0;
    chk(done == 1, "R6", "done at end", done, 1);
    chk(mem_we == 0, "R6", "idle we at done", mem_we, 0);
    chk(fail == with_fault, "R7", "fail at done", fail, with_fault);
    if (with_fault) chk(mism == 2*NW - NW + 10, "R7", "first mismatch cycle", mism, 74);
    @(negedge clk);
    chk(done == 0, "R6", "done pulse width", done, 0);
    for (int i = 0; i < 4; i++) begin
      chk(mem_we == 0, "R6", "idle after run", mem_we, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    test_mode = 1;
    repeat (3) @(negedge clk);
    chk(done == 0 && fail == 0, "R6", "reset outputs", {done, fail}, 0);
    chk(mem_we == 0, "R6", "reset we", mem_we, 0);
    rst_n = 1;
    @(negedge clk);

    // R5 functional path
    test_mode = 0;
    fn_addr = AW'(10); fn_wdata = 8'hA5; fn_we = 1;
    #0.5;
    chk(mem_addr == AW'(10) && mem_wdata == 8'hA5 && mem_we == 1, "R5", "functional drive",
        {mem_addr, mem_wdata, mem_we}, {AW'(10), 8'hA5, 1'b1});
    @(negedge clk);
    fn_we = 0; fn_addr = AW'(33); fn_wdata = 8'h3C;
    #0.5;
    chk(mem_we == 0 && mem_addr == AW'(33), "R5", "functional idle", {mem_addr, mem_we}, {AW'(33), 1'b0});
    fn_we = 1;
    @(negedge clk);
    fn_we = 0; fn_addr = AW'(10);
    #0.5;
    chk(fn_rdata == 8'hA5, "R5", "read return", fn_rdata, 8'hA5);
    fn_addr = AW'(33);
    #0.5;
    chk(fn_rdata == 8'h3C, "R5", "read return 2", fn_rdata, 8'h3C);

    // R8 start ignored in functional mode
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    test_mode = 1;
    for (int i = 0; i < 20; i++) begin
      chk(mem_we == 0 && done == 0, "R8", "start ignored in functional mode", {mem_we, done}, 0);
      @(negedge clk);
    end

    run_march(0, -1);       // R1 R2 R3 R4 R6
    run_march(1, 300);      // R7 fault, R8 restart poke mid-run
    run_march(0, -1);       // R7 cleared by new start

    report();
  end
endmodule